// File: doc/BRIEF.md
# Flash Revision Probe and Burst Latency Configurator

This block runs once after reset, or again each time it is started, on the host side of a synchronous flash interface. A start pulse launches a single read of the flash geometry table at the entry that holds the erase-region count. The read address depends on the bus width. The count that comes back tells two silicon revisions apart. Both revisions expose the same three usable regions: eight 8 Kb blocks, thirty 64 Kb blocks and eight 8 Kb blocks. The older revision also reports an extra region of zero size, so its count is one higher.

The two revisions map a 4-bit latency code to a different number of initial-access clock cycles. The block therefore derives the code from a target latency in cycles and from the revision it detected, so that the burst delay comes out the same on either revision. It then writes a configuration word that carries that code, with rising-edge data output selected. Both transfers use a request/acknowledge handshake. The result is reported on done and error, and the detected revision and the chosen code stay visible until the next start.

Top module: `lat_probe_top`

## Requirements
- R1: After a synchronous reset, rd_req, wr_req, done, error, rev_new and lat_code are all 0.
- R2: The bus width and target latency are sampled on the start pulse. The query address is 2Ch when wide_mode is 1 (32-bit bus) and 58h when wide_mode is 0 (16-bit bus).
- R3: rd_req stays high until a cycle in which rd_ack is high, and is low in the cycle after that. wr_req behaves the same way with wr_ack, and wr_data does not change while wr_req is high. The two requests are never high together.
- R4: A returned count of 3 marks the newer revision (rev_new=1). A count of 4 marks the older revision (rev_new=0).
- R5: The code is the target minus 2 on the newer revision and the target minus 3 on the older one. The configuration word has the code in bits 13..10, bit 6 set to 1, and every other bit 0.
- R6: A returned count other than 3 or 4 ends in error=1 with no configuration write, and rev_new and lat_code are left at 0.
- R7: A target whose code would fall outside 0..7 for the detected revision ends in error=1 with no write, and rev_new and lat_code are left at 0.
- R8: done, rev_new and lat_code hold until the next start pulse, whatever the other inputs do. A start pulse while a sequence is running has no effect. A start pulse in the done or error state runs a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a probe |
| wide_mode | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| tgt_lat | input | 5 | Target initial latency in clock cycles |
| rd_req | output | 1 | Query read request |
| rd_addr | output | 8 | Query read address |
| rd_ack | input | 1 | Read acknowledge, carries rd_data |
| rd_data | input | 16 | Returned geometry value |
| wr_req | output | 1 | Configuration write request |
| wr_data | output | 16 | Configuration word |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | Sequence finished with a write |
| error | output | 1 | Sequence aborted |
| rev_new | output | 1 | 1 = newer revision detected |
| lat_code | output | 4 | Latency code that was written |

## Verification
The handshake assertions assume that an acknowledge is a one-cycle pulse that only answers a request which is already visible. They also assume that rd_data is valid in the acknowledge cycle. The bench's responder keeps to this. It waits until it sees the request at a falling edge, then waits zero to three cycles, then raises the acknowledge for exactly one cycle together with the data. The hold property assumes that start is not pulsed during done unless a new run is intended. The bench changes only the sampled inputs, wide_mode and tgt_lat, while it checks the held results.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QREQ,
    ST_QWAIT,
    ST_DECODE,
    ST_WRCFG,
    ST_DONE,
    ST_ERROR
  } lpc_state_e;
endpackage

// File: rtl/lpc_rev_decode.sv
module lpc_rev_decode #(
  parameter int DATA_W  = 16,
  parameter int CNT_NEW = 3,
  parameter int CNT_OLD = 4
) (
  input  logic [DATA_W-1:0] count,
  output logic              known,
  output logic              is_new
);
  localparam logic [DATA_W-1:0] CNT_NEW_V = DATA_W'(CNT_NEW);
  localparam logic [DATA_W-1:0] CNT_OLD_V = DATA_W'(CNT_OLD);

  logic hit_new, hit_old;

  always_comb begin
    hit_new = (count == CNT_NEW_V);
    hit_old = (count == CNT_OLD_V);
    known   = hit_new | hit_old;
    is_new  = hit_new;
  end
endmodule

// File: rtl/lpc_lat_encode.sv
module lpc_lat_encode #(
  parameter int LAT_W   = 5,
  parameter int CODE_W  = 4,
  parameter int NEW_OFS = 2,
  parameter int OLD_OFS = 3
) (
  input  logic [LAT_W-1:0]  tgt,
  input  logic              is_new,
  output logic [CODE_W-1:0] code,
  output logic              fits
);
  localparam int CODE_MAX = (1 << (CODE_W - 1)) - 1;

  logic [1:0]              fit_v;
  logic [CODE_W-1:0]       code_v [2];

  // variant 0 = older revision, variant 1 = newer revision
  for (genvar v = 0; v < 2; v++) begin : g_rev
    localparam logic [LAT_W-1:0] OFS_V = LAT_W'((v == 1) ? NEW_OFS : OLD_OFS);
    logic [LAT_W-1:0] diff;
    assign diff      = tgt - OFS_V;
    assign fit_v[v]  = (tgt >= OFS_V) && (diff <= LAT_W'(CODE_MAX));
    assign code_v[v] = diff[CODE_W-1:0];
  end

  always_comb begin
    code = is_new ? code_v[1] : code_v[0];
    fits = is_new ? fit_v[1]  : fit_v[0];
  end
endmodule

// File: rtl/lpc_seq.sv
module lpc_seq
  import lpc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int LAT_W       = 5,
  parameter int CODE_W      = 4,
  parameter int CFG_W       = 16,
  parameter int CODE_LSB    = 10,
  parameter int EDGE_BIT    = 6,
  parameter int ADDR_WIDE   = 'h2C,
  parameter int ADDR_NARROW = 'h58
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wide_mode,
  input  logic [LAT_W-1:0]  tgt_lat,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [CFG_W-1:0]  wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic              error,
  output logic              rev_new,
  output logic [CODE_W-1:0] lat_code,
  output logic [DATA_W-1:0] cnt_q,
  output logic [LAT_W-1:0]  tgt_q,
  input  logic              dec_known,
  input  logic              dec_new,
  input  logic [CODE_W-1:0] enc_code,
  input  logic              enc_fits
);
  localparam logic [ADDR_W-1:0] A_WIDE   = ADDR_W'(ADDR_WIDE);
  localparam logic [ADDR_W-1:0] A_NARROW = ADDR_W'(ADDR_NARROW);

  lpc_state_e st, nxt;
  logic       accept_start, rd_done;

  function automatic logic [CFG_W-1:0] cfg_word(input logic [CODE_W-1:0] c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[CODE_LSB +: CODE_W] = c;
    w[EDGE_BIT] = 1'b1;
    return w;
  endfunction

  always_comb begin
    accept_start = start && (st == ST_IDLE || st == ST_DONE || st == ST_ERROR);
    rd_done      = rd_ack && (st == ST_QREQ || st == ST_QWAIT);
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:   if (start) nxt = ST_QREQ;
      ST_QREQ,
      ST_QWAIT:  nxt = rd_ack ? ST_DECODE : ST_QWAIT;
      ST_DECODE: nxt = (dec_known && enc_fits) ? ST_WRCFG : ST_ERROR;
      ST_WRCFG:  if (wr_ack) nxt = ST_DONE;
      ST_DONE,
      ST_ERROR:  if (start) nxt = ST_QREQ;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      rd_req   <= 1'b0;
      wr_req   <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      rd_addr  <= '0;
      wr_data  <= '0;
      rev_new  <= 1'b0;
      lat_code <= '0;
      cnt_q    <= '0;
      tgt_q    <= '0;
    end else begin
      st     <= nxt;
      rd_req <= (nxt == ST_QREQ) || (nxt == ST_QWAIT);
      wr_req <= (nxt == ST_WRCFG);
      done   <= (nxt == ST_DONE);
      error  <= (nxt == ST_ERROR);
      if (accept_start) begin
        rd_addr  <= wide_mode ? A_WIDE : A_NARROW;
        tgt_q    <= tgt_lat;
        rev_new  <= 1'b0;
        lat_code <= '0;
        wr_data  <= '0;
      end
      if (rd_done) cnt_q <= rd_data;
      if (st == ST_DECODE && nxt == ST_WRCFG) begin
        rev_new  <= dec_new;
        lat_code <= enc_code;
        wr_data  <= cfg_word(enc_code);
      end
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req); // R3
  AST_RD_DROP: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_ack |=> !rd_req); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_req && !wr_ack |=> wr_req && $stable(wr_data)); // R3
  AST_ONE_BUS: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req)); // R3
  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr == A_WIDE) || (rd_addr == A_NARROW)); // R2
  AST_WR_FORMAT: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> wr_data[EDGE_BIT] && (wr_data[CODE_LSB +: CODE_W] == lat_code)); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done && $stable(lat_code) && $stable(rev_new)); // R8
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && error)); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> !rev_new && (lat_code == '0)); // R7
endmodule

// File: rtl/lat_probe_top.sv
module lat_probe_top #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int LAT_W       = 5,
  parameter int CODE_W      = 4,
  parameter int CFG_W       = 16,
  parameter int CODE_LSB    = 10,
  parameter int EDGE_BIT    = 6,
  parameter int ADDR_WIDE   = 'h2C,
  parameter int ADDR_NARROW = 'h58,
  parameter int CNT_NEW     = 3,
  parameter int CNT_OLD     = 4,
  parameter int NEW_OFS     = 2,
  parameter int OLD_OFS     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wide_mode,
  input  logic [LAT_W-1:0]  tgt_lat,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [CFG_W-1:0]  wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic              error,
  output logic              rev_new,
  output logic [CODE_W-1:0] lat_code
);
  logic [DATA_W-1:0] cnt_q;
  logic [LAT_W-1:0]  tgt_q;
  logic              dec_known, dec_new, enc_fits;
  logic [CODE_W-1:0] enc_code;

  lpc_rev_decode #(
    .DATA_W (DATA_W),
    .CNT_NEW(CNT_NEW),
    .CNT_OLD(CNT_OLD)
  ) u_dec (
    .count (cnt_q),
    .known (dec_known),
    .is_new(dec_new)
  );

  lpc_lat_encode #(
    .LAT_W  (LAT_W),
    .CODE_W (CODE_W),
    .NEW_OFS(NEW_OFS),
    .OLD_OFS(OLD_OFS)
  ) u_enc (
    .tgt   (tgt_q),
    .is_new(dec_new),
    .code  (enc_code),
    .fits  (enc_fits)
  );

  lpc_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LAT_W      (LAT_W),
    .CODE_W     (CODE_W),
    .CFG_W      (CFG_W),
    .CODE_LSB   (CODE_LSB),
    .EDGE_BIT   (EDGE_BIT),
    .ADDR_WIDE  (ADDR_WIDE),
    .ADDR_NARROW(ADDR_NARROW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wide_mode(wide_mode),
    .tgt_lat  (tgt_lat),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ack   (rd_ack),
    .rd_data  (rd_data),
    .wr_req   (wr_req),
    .wr_data  (wr_data),
    .wr_ack   (wr_ack),
    .done     (done),
    .error    (error),
    .rev_new  (rev_new),
    .lat_code (lat_code),
    .cnt_q    (cnt_q),
    .tgt_q    (tgt_q),
    .dec_known(dec_known),
    .dec_new  (dec_new),
    .enc_code (enc_code),
    .enc_fits (enc_fits)
  );
endmodule

// File: tb/sim_lat_probe_top.sv
`timescale 1ns/1ps
module sim_lat_probe_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        wide_mode = 1'b0;
  logic [4:0]  tgt_lat = '0;
  logic        rd_req;
  logic [7:0]  rd_addr;
  logic        rd_ack = 1'b0;
  logic [15:0] rd_data = '0;
  logic        wr_req;
  logic [15:0] wr_data;
  logic        wr_ack = 1'b0;
  logic        done, error, rev_new;
  logic [3:0]  lat_code;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  lat_probe_top u0 (
    .clk(clk), .rst(rst), .start(start), .wide_mode(wide_mode), .tgt_lat(tgt_lat),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
    .done(done), .error(error), .rev_new(rev_new), .lat_code(lat_code)
  );

  // fields: wide[19] cnt[18:11] tgt[10:6] err[5] rev[4] code[3:0]
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 8'h03, 5'd5,  1'b0, 1'b1, 4'd3},
    {1'b0, 8'h03, 5'd2,  1'b0, 1'b1, 4'd0},
    {1'b1, 8'h03, 5'd9,  1'b0, 1'b1, 4'd7},
    {1'b0, 8'h04, 5'd3,  1'b0, 1'b0, 4'd0},
    {1'b1, 8'h04, 5'd10, 1'b0, 1'b0, 4'd7},
    {1'b0, 8'h04, 5'd6,  1'b0, 1'b0, 4'd3},
    {1'b1, 8'h03, 5'd1,  1'b1, 1'b0, 4'd0},
    {1'b1, 8'h03, 5'd10, 1'b1, 1'b0, 4'd0},
    {1'b0, 8'h04, 5'd2,  1'b1, 1'b0, 4'd0},
    {1'b1, 8'h04, 5'd11, 1'b1, 1'b0, 4'd0},
    {1'b1, 8'h05, 5'd5,  1'b1, 1'b0, 4'd0},
    {1'b0, 8'h00, 5'd5,  1'b1, 1'b0, 4'd0},
    {1'b1, 8'h02, 5'd4,  1'b1, 1'b0, 4'd0},
    {1'b0, 8'h04, 5'd31, 1'b1, 1'b0, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic w, input logic [7:0] cnt, input logic [4:0] tgt,
                         input logic xerr, input logic xrev, input logic [3:0] xcode,
                         input int dly);
    int    n;
    bit    saw_wr, rd_again;
    string etag;
    logic [15:0] xword;
    etag  = (cnt == 8'h03 || cnt == 8'h04) ? "R7" : "R6";
    xword = {2'b00, xcode, 3'b000, 1'b1, 6'b000000};
    saw_wr = 0; rd_again = 0;
    @(negedge clk);
    wide_mode = w; tgt_lat = tgt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wide_mode = ~w; tgt_lat = ~tgt;          // R2: later changes must not matter
    n = 0;
    while (!rd_req && n < 50) begin @(negedge clk); n++; end
    chk(rd_req, "R3", rd_req, 1);
    chk(rd_addr == (w ? 8'h2C : 8'h58), "R2", rd_addr, w ? 8'h2C : 8'h58);
    for (int k = 0; k < dly; k++) begin
      if (k == 0) start = 1'b1;              // R8: start while busy is ignored
      @(negedge clk);
      start = 1'b0;
      chk(rd_req, "R3", rd_req, 1);
    end
    rd_ack = 1'b1; rd_data = {8'h00, cnt};
    @(negedge clk);
    rd_ack = 1'b0; rd_data = '0;
    chk(!rd_req, "R3", rd_req, 0);
    n = 0;
    while (!wr_req && !done && !error && n < 50) begin
      if (rd_req) rd_again = 1;
      @(negedge clk); n++;
    end
    if (wr_req) begin
      saw_wr = 1;
      chk(wr_data == xword, "R5", wr_data, xword);
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk(wr_req && wr_data == xword, "R3", wr_data, xword);
      end
      wr_ack = 1'b1;
      @(negedge clk);
      wr_ack = 1'b0;
      chk(!wr_req, "R3", wr_req, 0);
    end
    n = 0;
    while (!done && !error && n < 50) begin
      if (rd_req) rd_again = 1;
      @(negedge clk); n++;
    end
    chk(!rd_again, "R8", rd_again, 0);
    chk(error == xerr, xerr ? etag : "R5", error, xerr);
    chk(done == !xerr, xerr ? etag : "R5", done, !xerr);
    chk(saw_wr == !xerr, xerr ? etag : "R5", saw_wr, !xerr);
    chk(rev_new == xrev, xerr ? etag : "R4", rev_new, xrev);
    chk(lat_code == xcode, xerr ? etag : "R5", lat_code, xcode);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected <= 20000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [3:0] hold_code;
    logic       hold_rev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!rd_req && !wr_req, "R1", {rd_req, wr_req}, 0);
    chk(!done && !error, "R1", {done, error}, 0);
    chk(!rev_new && lat_code == 0, "R1", {rev_new, lat_code}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      run_vec(v[19], v[18:11], v[10:6], v[5], v[4], v[3:0], i % 4);
    end

    // R8: a successful result holds while inputs change without start
    run_vec(1'b1, 8'h04, 5'd7, 1'b0, 1'b0, 4'd4, 2);
    hold_code = lat_code; hold_rev = rev_new;
    for (int k = 0; k < 6; k++) begin
      wide_mode = k[0]; tgt_lat = 5'(k * 3);
      @(negedge clk);
      chk(done && lat_code == hold_code && rev_new == hold_rev && !rd_req,
          "R8", {done, rev_new, lat_code}, {1'b1, hold_rev, hold_code});
    end

    // R1: reset in the middle of a query
    @(negedge clk);
    wide_mode = 1'b1; tgt_lat = 5'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(rd_req, "R3", rd_req, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!rd_req && !wr_req && !done && !error && !rev_new && lat_code == 0,
        "R1", {rd_req, wr_req, done, error, rev_new, lat_code}, 0);

    // R8: rerun from the error state after a clean result
    run_vec(1'b0, 8'h07, 5'd5, 1'b1, 1'b0, 4'd0, 1);
    run_vec(1'b0, 8'h03, 5'd6, 1'b0, 1'b1, 4'd4, 0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule